// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

This block manages one bank of general-purpose pins behind a small word-addressed register bus. Each pin can be owned by the GPIO logic or handed to one of two on-chip peripheral functions, A or B. When GPIO owns a pin, the block drives the pad from its own level and drive-enable state, either push-pull or open-drain. When a peripheral owns it, the chosen peripheral's output and drive enable go straight to the pad. The block also drives the per-pin pull-up enables and shows the synchronized, optionally glitch-filtered pad levels as a status word.

Every per-pin attribute sits in one state register and is changed only through a pair of write-only registers. Writing a mask to the "raise" register sets the pins whose mask bit is one. Writing a mask to the "lower" register clears them. Software can therefore change any group of pins without a read-modify-write. The attributes are GPIO ownership, drive enable, output level, pull-up, peripheral B choice, input filter and open-drain. Attribute k uses word address 4k for raise, 4k+1 for lower and 4k+2 for its status. The order of k is: ownership 0, drive 1, level 2, pull-up 3, B choice 4, filter 5, open-drain 6. The pad level word is at address 28.

Top module: `pin_mux_bank`

## Requirements
- R1: After reset every pin is owned by GPIO (ownership status all ones), drive enables are off, output levels are zero, pull-ups are on (status all ones), peripheral A is chosen (B-choice status zero), and the filter and open-drain are off.
- R2: A write to a raise address sets exactly the pins whose mask bit is one, and a write to a lower address clears exactly those pins. Mask bits that are zero leave their pins unchanged. The new state is in effect from the clock edge that takes the write.
- R3: A read is answered on `bus_rdata` in the cycle after the request. A status address returns the attribute's current mask, a raise or lower address returns zero, and `bus_rdata` is zero in any cycle after which no read was requested.
- R4: For a GPIO-owned pin without open-drain, `pad_out` equals the pin's output level and `pad_oe` equals its drive enable.
- R5: For a pin not owned by GPIO, `pad_out` and `pad_oe` come from peripheral B when the pin's B-choice bit is one, and from peripheral A when it is zero.
- R6: For a GPIO-owned pin with open-drain on, `pad_out` is zero and `pad_oe` is one only when drive is enabled and the level is zero. Open-drain has no effect on peripheral-owned pins.
- R7: `pad_pullup` equals the pull-up attribute mask at all times.
- R8: With the filter off, a change on `pad_in` shows on `pin_level` three clock edges later, whatever owns the pin. `pin_level` is also readable at address 28.
- R9: With the filter on, a pad change shows on `pin_level` four edges later, and a pad pulse that lasts one clock cycle never reaches `pin_level`.
- R10: Addresses whose low two bits are 3, and addresses 29 to 31, read as zero, and writes to them change no attribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | NPINS | Write mask |
| bus_rdata | output | NPINS | Read data, one cycle after `bus_rd` |
| pad_in | input | NPINS | Sampled pad levels (asynchronous) |
| pad_out | output | NPINS | Per-pin output value to the pads |
| pad_oe | output | NPINS | Per-pin output drive enable |
| pad_pullup | output | NPINS | Per-pin pull-up enable |
| pin_level | output | NPINS | Synchronized, optionally filtered pad levels |
| pa_out | input | NPINS | Peripheral A output values |
| pa_oe | input | NPINS | Peripheral A drive enables |
| pb_out | input | NPINS | Peripheral B output values |
| pb_oe | input | NPINS | Peripheral B drive enables |

## Verification
Attribute writes take effect at the edge that takes them, so pad outputs and pull-ups are due one edge after the write strobe. Read data is due one edge after the read strobe. Pad levels take three edges, or four with filtering. The bench drives inputs just after a rising edge and compares every output with a behavioural model at the falling edge, so each result is seen in the cycle it is due. The directed checks count edges explicitly: the unfiltered level must be absent after two edges and present after three, and the filtered level must be absent after three and present after four.

// File: rtl/pmb_pkg.sv
package pmb_pkg;

    localparam int NATTR  = 7;
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        ATTR_GPIO  = 3'd0,
        ATTR_DRIVE = 3'd1,
        ATTR_LEVEL = 3'd2,
        ATTR_PULL  = 3'd3,
        ATTR_SELB  = 3'd4,
        ATTR_FILT  = 3'd5,
        ATTR_OPEN  = 3'd6
    } attr_e;

    typedef enum logic [1:0] {
        SLOT_RAISE = 2'd0,
        SLOT_LOWER = 2'd1,
        SLOT_STAT  = 2'd2,
        SLOT_NONE  = 2'd3
    } slot_e;

    localparam logic [ADDR_W-1:0] ADDR_PADLVL = 5'd28;

    // reset value of every bit of attribute k
    function automatic logic attr_reset_one(int k);
        return (k == int'(ATTR_GPIO)) || (k == int'(ATTR_PULL));
    endfunction

endpackage

// File: rtl/pmb_attr_reg.sv
module pmb_attr_reg #(
    parameter int W       = 32,
    parameter bit RST_ONE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raise_mask,
    input  logic [W-1:0] lower_mask,
    output logic [W-1:0] state
);

    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // lower takes precedence over raise on the same bit
        st_d.bits = (st_q.bits | raise_mask) & ~lower_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.bits <= {W{RST_ONE}};
        else        st_q <= st_d;
    end

    assign state = st_q.bits;

endmodule

// File: rtl/pmb_in_sync.sv
module pmb_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] filt_en,
    output logic [W-1:0] level
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
        logic [W-1:0] lvl;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = pad_in;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
        for (int i = 0; i < W; i++) begin
            if (!filt_en[i])
                sy_d.lvl[i] = sy_q.s2[i];
            else if (sy_q.s2[i] == sy_q.s3[i])
                sy_d.lvl[i] = sy_q.s2[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign level = sy_q.lvl;

    // R9: a filtered pin does not move while its last two samples disagree
    a_r9_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt_en & (sy_q.s2 ^ sy_q.s3)) != '0) |=>
            ((($past(filt_en) & ($past(sy_q.s2) ^ $past(sy_q.s3))) &
              (level ^ $past(level))) == '0));

endmodule

// File: rtl/pmb_pad_mux.sv
module pmb_pad_mux #(
    parameter int W = 32
) (
    input  logic [W-1:0] gpio_own,
    input  logic [W-1:0] drive_en,
    input  logic [W-1:0] out_level,
    input  logic [W-1:0] open_drain,
    input  logic [W-1:0] sel_b,
    input  logic [W-1:0] pa_out,
    input  logic [W-1:0] pa_oe,
    input  logic [W-1:0] pb_out,
    input  logic [W-1:0] pb_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (gpio_own[i]) begin
                if (open_drain[i]) begin
                    pad_out[i] = 1'b0;
                    pad_oe[i]  = drive_en[i] & ~out_level[i];
                end else begin
                    pad_out[i] = out_level[i];
                    pad_oe[i]  = drive_en[i];
                end
            end else if (sel_b[i]) begin
                pad_out[i] = pb_out[i];
                pad_oe[i]  = pb_oe[i];
            end else begin
                pad_out[i] = pa_out[i];
                pad_oe[i]  = pa_oe[i];
            end
        end
    end

endmodule

// File: rtl/pin_mux_bank.sv
module pin_mux_bank
    import pmb_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pullup,
    output logic [NPINS-1:0]  pin_level,
    input  logic [NPINS-1:0]  pa_out,
    input  logic [NPINS-1:0]  pa_oe,
    input  logic [NPINS-1:0]  pb_out,
    input  logic [NPINS-1:0]  pb_oe
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] a_idx;
    slot_e            a_slot;
    logic [NPINS-1:0] raise_m [NATTR];
    logic [NPINS-1:0] lower_m [NATTR];
    logic [NPINS-1:0] attr    [NATTR];
    logic [NPINS-1:0] rd_val;

    assign a_idx  = bus_addr[ADDR_W-1:2];
    assign a_slot = slot_e'(bus_addr[1:0]);

    for (genvar k = 0; k < NATTR; k++) begin : g_attr
        assign raise_m[k] = (bus_wr && a_idx == IDX_W'(k) && a_slot == SLOT_RAISE)
                            ? bus_wdata : '0;
        assign lower_m[k] = (bus_wr && a_idx == IDX_W'(k) && a_slot == SLOT_LOWER)
                            ? bus_wdata : '0;
        pmb_attr_reg #(
            .W       (NPINS),
            .RST_ONE (attr_reset_one(k))
        ) u_attr (
            .clk        (clk),
            .rst_n      (rst_n),
            .raise_mask (raise_m[k]),
            .lower_mask (lower_m[k]),
            .state      (attr[k])
        );
    end

    pmb_in_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pad_in),
        .filt_en (attr[ATTR_FILT]),
        .level   (pin_level)
    );

    pmb_pad_mux #(.W(NPINS)) u_mux (
        .gpio_own   (attr[ATTR_GPIO]),
        .drive_en   (attr[ATTR_DRIVE]),
        .out_level  (attr[ATTR_LEVEL]),
        .open_drain (attr[ATTR_OPEN]),
        .sel_b      (attr[ATTR_SELB]),
        .pa_out     (pa_out),
        .pa_oe      (pa_oe),
        .pb_out     (pb_out),
        .pb_oe      (pb_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    assign pad_pullup = attr[ATTR_PULL];

    // read mux
    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NATTR; k++) begin
            if (a_idx == IDX_W'(k) && a_slot == SLOT_STAT) rd_val = attr[k];
        end
        if (bus_addr == ADDR_PADLVL) rd_val = pin_level;
    end

    typedef struct packed {
        logic [NPINS-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d       = rd_q;
        rd_d.rdata = bus_rd ? rd_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    // R2: after a raise write to drive enable, every masked pin is enabled
    a_r2_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'd4) |=>
            ((attr[ATTR_DRIVE] & $past(bus_wdata)) == $past(bus_wdata)));

    // R3: raise and lower addresses read back as zero
    a_r3_pair_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (a_slot == SLOT_RAISE || a_slot == SLOT_LOWER) &&
         bus_addr != ADDR_PADLVL) |=> (bus_rdata == '0));

    // R6: an open-drain GPIO pin never drives high
    a_r6_open_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((attr[ATTR_GPIO] & attr[ATTR_OPEN] & pad_out) == '0));

    // R10: writes to unmapped addresses leave every attribute alone
    a_r10_hole_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (a_slot == SLOT_NONE || a_idx == IDX_W'(NATTR))) |=>
            ($stable(attr[ATTR_GPIO]) && $stable(attr[ATTR_DRIVE]) &&
             $stable(attr[ATTR_LEVEL]) && $stable(attr[ATTR_PULL]) &&
             $stable(attr[ATTR_SELB]) && $stable(attr[ATTR_FILT]) &&
             $stable(attr[ATTR_OPEN])));

endmodule

// File: tb/pin_mux_bank_bench.sv
module pin_mux_bank_bench;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata, pad_out, pad_oe, pad_pullup, pin_level;
    logic [N-1:0] pad_in = '0, pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pin_mux_bank u_pin_mux_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pullup(pad_pullup), .pin_level(pin_level),
        .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe)
    );

    // behavioural reference model
    logic [N-1:0] m_attr [7];
    logic [N-1:0] m_rdata = '0;
    logic [N-1:0] m_pipe [$];
    logic [N-1:0] m_s3 = '0, m_lvl = '0;

    function automatic void m_reset();
        for (int k = 0; k < 7; k++) m_attr[k] = (k == 0 || k == 3) ? '1 : '0;
        m_rdata = '0; m_s3 = '0; m_lvl = '0;
        m_pipe = {};
        m_pipe.push_back('0); m_pipe.push_back('0);
    endfunction

    initial m_reset();

    function automatic logic [N-1:0] m_read(logic [4:0] a);
        if (a == 5'd28) return m_lvl;
        if (a[1:0] == 2'd2 && a[4:2] < 3'd7) return m_attr[a[4:2]];
        return '0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            logic [N-1:0] s2;
            s2 = m_pipe[1];
            for (int i = 0; i < N; i++)
                if (!m_attr[5][i] || s2[i] == m_s3[i]) m_lvl[i] = s2[i];
            m_s3 = s2;
            void'(m_pipe.pop_back());
            m_pipe.push_front(pad_in);
            m_rdata = bus_rd ? m_read(bus_addr) : '0;
            if (bus_wr && bus_addr[4:2] < 3'd7) begin
                if (bus_addr[1:0] == 2'd0) m_attr[bus_addr[4:2]] |= bus_wdata;
                if (bus_addr[1:0] == 2'd1) m_attr[bus_addr[4:2]] &= ~bus_wdata;
            end
        end
    end

    function automatic void m_pads(output logic [N-1:0] po, output logic [N-1:0] pe);
        for (int i = 0; i < N; i++) begin
            if (m_attr[0][i]) begin
                po[i] = m_attr[6][i] ? 1'b0 : m_attr[2][i];
                pe[i] = m_attr[6][i] ? (m_attr[1][i] && !m_attr[2][i]) : m_attr[1][i];
            end else begin
                po[i] = m_attr[4][i] ? pb_out[i] : pa_out[i];
                pe[i] = m_attr[4][i] ? pb_oe[i]  : pa_oe[i];
            end
        end
    endfunction

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare against the model every clock, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [N-1:0] po, pe;
            m_pads(po, pe);
            chk("R3 rdata", bus_rdata, m_rdata);
            chk("R4,R5,R6 pad_out", pad_out, po);
            chk("R4,R5,R6 pad_oe", pad_oe, pe);
            chk("R7 pullup", pad_pullup, m_attr[3]);
            chk("R8 level", pin_level, m_lvl);
        end
    end

    task automatic wr(logic [4:0] a, logic [N-1:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [4:0] a, output logic [N-1:0] d);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic edges(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [N-1:0] d;
        edges(4);
        rst_n = 1'b1;
        edges(1);
        // R1 reset state
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pullup", pad_pullup, '1);
        rd(5'd2, d);  chk("R1 gpio status", d, '1);
        rd(5'd14, d); chk("R1 pull status", d, '1);
        rd(5'd18, d); chk("R1 selb status", d, '0);
        rd(5'd26, d); chk("R1 open status", d, '0);
        edges(1); chk("R3 idle rdata", bus_rdata, '0);

        // R2/R4 raise and lower, push-pull GPIO
        wr(5'd8, 32'h0000_00F0);
        wr(5'd4, 32'h0000_FFFF);
        chk("R4 out", pad_out, 32'h0000_00F0);
        chk("R4 oe", pad_oe, 32'h0000_FFFF);
        wr(5'd4, 32'h0001_0000);
        chk("R2 raise keeps others", pad_oe, 32'h0001_FFFF);
        wr(5'd9, 32'h0000_0030);
        chk("R2 lower", pad_out, 32'h0000_00C0);
        rd(5'd8, d);  chk("R3 raise reads zero", d, '0);
        rd(5'd10, d); chk("R3 level status", d, 32'h0000_00C0);

        // R6 open-drain
        wr(5'd24, 32'h0000_00FF);
        chk("R6 od out", pad_out & 32'hFF, 32'h0);
        chk("R6 od oe", pad_oe & 32'hFF, 32'h3F);

        // R5 peripheral mux
        pa_out = 32'hAAAA_AAAA; pa_oe = 32'h0F0F_0F0F;
        pb_out = 32'h5555_5555; pb_oe = 32'hFFFF_0000;
        wr(5'd1, 32'hFFFF_0000);
        wr(5'd16, 32'hFF00_0000);
        chk("R5 out", pad_out & 32'hFFFF_0000, 32'h55AA_0000);
        chk("R5 oe", pad_oe & 32'hFFFF_0000, 32'hFF0F_0000);
        wr(5'd24, 32'hFF00_0000);
        chk("R6 no effect on peripheral", pad_out & 32'hFF00_0000, 32'h5500_0000);

        // R7 pull-up
        wr(5'd13, 32'h0000_FFFF);
        chk("R7 pullup", pad_pullup, 32'hFFFF_0000);

        // R8 unfiltered level latency, GPIO and peripheral pins alike
        @(posedge clk); #1; pad_in = 32'h1234_5678;
        edges(2); chk("R8 not yet", pin_level, 32'h0);
        edges(1); chk("R8 after three", pin_level, 32'h1234_5678);
        rd(5'd28, d); chk("R8 read", d, 32'h1234_5678);

        // R9 filter
        wr(5'd20, 32'hFFFF_FFFF);
        edges(2);
        @(posedge clk); #1; pad_in = 32'h1234_5679;
        @(posedge clk); #1; pad_in = 32'h1234_5678;
        for (int i = 0; i < 6; i++) begin
            edges(1); chk("R9 pulse blocked", pin_level, 32'h1234_5678);
        end
        @(posedge clk); #1; pad_in = 32'hFFFF_0000;
        edges(3); chk("R9 not yet", pin_level, 32'h1234_5678);
        edges(1); chk("R9 after four", pin_level, 32'hFFFF_0000);

        // R10 unmapped addresses
        wr(5'd3, '1);
        wr(5'd30, '1);
        wr(5'd15, '1);
        rd(5'd3, d);  chk("R10 read hole", d, '0);
        rd(5'd31, d); chk("R10 read top", d, '0);
        rd(5'd6, d);  chk("R10 drive untouched", d, 32'h0001_FFFF);
        rd(5'd14, d); chk("R10 pull untouched", d, 32'hFFFF_0000);

        edges(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule